// File: doc/BRIEF.md
# ALU Result Byte Packer

This block sits on the output side of a byte-serial ALU pipeline. Each ALU operation needs two operand loads per byte, so result bytes arrive with a gap after each one: one meaningful byte, one slot of junk, then the next byte. The packer holds the early bytes back inside a short chain of byte registers. It then releases all of them on consecutive clocks. The first packed byte leaves in the clock right after the last byte of the operation has been fed in, so the output burst overlaps the time that would otherwise be spent waiting.

The chain is steered by one flow bit from the sequencer. While flow is 1, every register hands its byte to the next one. When the first result byte has reached the last register, flow drops to 0 for one clock fewer than the chain length. A zero that has lasted long enough freezes the later registers one after another, so the junk slots are squeezed out. When flow stays at 1 all the time, the chain is a plain pipeline, which suits chained operations that deliver a valid byte every clock. A single enable freezes all state while the ALU is idle.

Top module: `res_packer`

## Requirements
- R1: Reset is synchronous and active low. After a clock edge with `rst_n` low, `pack_out` is 0 and `pack_vld` is 0.
- R2: While `flow_in` is 1 on the current enabled clock and on the two enabled clocks before it (chain depth 4), the byte presented on `res_in` three enabled clocks earlier is on `pack_out` after that edge. This gives a straight pipeline of four registers.
- R3: A packed operation feeds bytes b0..b3 on enabled clocks t, t+2, t+4 and t+6. `flow_in` is 1 on clocks t..t+3 and 0 on clocks t+4..t+6. After the edges ending clocks t+6, t+7, t+8 and t+9, `pack_out` shows b0, b1, b2 and b3 in that order.
- R4: `pack_vld` is 1 for exactly the four enabled clocks that follow the edges listed in R3. It is 0 at all other times, including the whole time `flow_in` is held at 1.
- R5: The bytes on `res_in` in the gap clocks t+1, t+3 and t+5 of a packed operation have no effect on the packed bytes.
- R6: On a clock where `en` is 0, `pack_out` and `pack_vld` keep their values, and `res_in` and `flow_in` are ignored. Later operation resumes as if that clock had not happened.
- R7: A new packed operation may begin on clock t+7, the clock right after the previous operation's last byte. This does not disturb the output burst of the previous operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Shared enable for all state; 0 freezes the block |
| flow_in | input | 1 | Flow bit: 1 moves bytes along, a run of 0 packs them |
| res_in | input | WIDTH | Result byte from the ALU |
| pack_out | output | WIDTH | Byte held in the last register of the chain |
| pack_vld | output | 1 | High while the last register holds a packed result byte |

## Verification
The hardest case to reach is a stall that lands in the middle of a packing run. In that case the flow history, the partly frozen chain and the drain count must all survive a gap of disabled clocks. Packed operations are placed at random offsets, some of them back to back. Stall bursts of one to three disabled clocks, carrying random bytes and flow values, are inserted at random between enabled clocks. This way pauses fall inside the zero window, inside the output burst and on the boundary between two operations. The junk bytes in the gap slots are random, and in one directed operation they are the complement of the real bytes.

// File: rtl/res_pack_pkg.sv
// Shared definitions for the result byte packer.
// Assumes: chain depth of at least 3 so that a flow history exists.
package res_pack_pkg;

    localparam int unsigned DEF_WIDTH = 8;
    localparam int unsigned DEF_DEPTH = 4;

    // Selects whether a chain register loads its predecessor or keeps its byte.
    typedef enum logic {
        ST_PASS = 1'b0,
        ST_KEEP = 1'b1
    } stage_mode_e;

    // Width of a counter that must hold values 0..depth-1.
    function automatic int unsigned cnt_bits(input int unsigned depth);
        return (depth < 3) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/res_pack_flow.sv
// Flow tracker: keeps the last DEPTH-2 flow samples and works out, for each
// chain register, whether the current run of zeros is long enough to freeze
// it. The last register freezes on the first zero and the second register
// only on the (DEPTH-1)-th. It also flags the clock that starts the output
// burst.
// Assumes: DEPTH >= 3; history resets to ones so no zero run is pending.
module res_pack_flow #(
    parameter int unsigned DEPTH = res_pack_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flow_in,
    output logic [DEPTH-1:0] hold_o,
    output logic             drain_go
);

    localparam int unsigned HIST_W = DEPTH - 2;

    logic [HIST_W-1:0] hist;
    logic [HIST_W:0]   zero_run;

    // Shift the flow bit into the history on every enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '1;
        end else if (en) begin
            hist[0] <= flow_in;
            for (int j = 1; j < int'(HIST_W); j++) begin
                hist[j] <= hist[j-1];
            end
        end
    end

    // zero_run[m]: flow was 0 now and on the m enabled clocks before.
    assign zero_run[0] = !flow_in;

    genvar m;
    generate
        for (m = 1; m <= int'(HIST_W); m++) begin : g_run
            assign zero_run[m] = zero_run[m-1] & !hist[m-1];
        end
    endgenerate

    // Register k (1-based) keeps its byte once the zero run spans DEPTH-k+1 clocks.
    assign hold_o[0] = 1'b0;

    genvar k;
    generate
        for (k = 1; k < int'(DEPTH); k++) begin : g_hold
            assign hold_o[k] = zero_run[DEPTH-1-k];
        end
    endgenerate

    // The longest run is the one that completes the packing.
    assign drain_go = en & zero_run[HIST_W];

endmodule

// File: rtl/res_pack_mark.sv
// Burst marker: raises the valid flag on the edge that completes packing and
// keeps it up for DEPTH enabled clocks while the packed bytes leave.
// Assumes: drain_go is only pulsed once per packed operation.
module res_pack_mark #(
    parameter int unsigned DEPTH = res_pack_pkg::DEF_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic drain_go,
    output logic vld
);

    localparam int unsigned CW = res_pack_pkg::cnt_bits(DEPTH);

    logic [CW-1:0] left;

    // Count down the bytes still to leave after the first packed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            vld  <= 1'b0;
        end else if (en) begin
            if (drain_go) begin
                left <= CW'(DEPTH - 1);
                vld  <= 1'b1;
            end else if (left != '0) begin
                left <= left - 1'b1;
                vld  <= 1'b1;
            end else begin
                vld  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/res_pack_stage.sv
// One byte register of the packing chain. The head register always loads the
// incoming byte. Every later register has a 2:1 choice between its
// predecessor and its own byte.
// Assumes: hold is only raised for non-head registers.
module res_pack_stage #(
    parameter int unsigned WIDTH = res_pack_pkg::DEF_WIDTH,
    parameter bit          FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold,
    input  logic [WIDTH-1:0] d_new,
    output logic [WIDTH-1:0] q
);

    import res_pack_pkg::*;

    stage_mode_e      mode;
    logic [WIDTH-1:0] nxt;

    assign mode = (!FIRST && hold) ? ST_KEEP : ST_PASS;

    // Pick the next byte for this register.
    always_comb begin
        case (mode)
            ST_KEEP: nxt = q;
            default: nxt = d_new;
        endcase
    end

    // Store the selected byte on enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/res_packer.sv
// Top of the result byte packer. It has a chain of DEPTH byte registers, a
// flow tracker that freezes the tail of the chain during a zero run, and a
// burst marker for the packed output.
// Assumes: sparse bytes arrive every second clock and the flow bit follows
// the pattern in the brief.
module res_packer #(
    parameter int unsigned WIDTH = res_pack_pkg::DEF_WIDTH,
    parameter int unsigned DEPTH = res_pack_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flow_in,
    input  logic [WIDTH-1:0] res_in,
    output logic [WIDTH-1:0] pack_out,
    output logic             pack_vld
);

    logic [DEPTH:0][WIDTH-1:0] chain;
    logic [DEPTH-1:0]          hold;
    logic                      drain_go;

    assign chain[0] = res_in;

    res_pack_flow #(.DEPTH(DEPTH)) u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .flow_in  (flow_in),
        .hold_o   (hold),
        .drain_go (drain_go)
    );

    genvar g;
    generate
        for (g = 0; g < int'(DEPTH); g++) begin : g_stage
            res_pack_stage #(
                .WIDTH (WIDTH),
                .FIRST (g == 0)
            ) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .hold  (hold[g]),
                .d_new (chain[g]),
                .q     (chain[g+1])
            );
        end
    endgenerate

    res_pack_mark #(.DEPTH(DEPTH)) u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .drain_go (drain_go),
        .vld      (pack_vld)
    );

    assign pack_out = chain[DEPTH];

endmodule

// File: rtl/res_packer_chk.sv
// Property checker for the result byte packer, attached by bind. It keeps a
// small reference history of enabled clocks to check the straight pipeline
// and the burst length.
module res_packer_chk #(
    parameter int unsigned WIDTH = res_pack_pkg::DEF_WIDTH,
    parameter int unsigned DEPTH = res_pack_pkg::DEF_DEPTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             flow_in,
    input logic [WIDTH-1:0] res_in,
    input logic [WIDTH-1:0] pack_out,
    input logic             pack_vld
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic [DEPTH-1:0][WIDTH-1:0] din_hist;
    logic [CW-1:0]               ones_cnt;
    logic [CW-1:0]               seen;
    logic [CW-1:0]               vld_run;

    // Record inputs and runs over enabled clocks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_hist <= '0;
            ones_cnt <= '0;
            seen     <= '0;
            vld_run  <= '0;
        end else if (en) begin
            din_hist[0] <= res_in;
            for (int j = 1; j < int'(DEPTH); j++) begin
                din_hist[j] <= din_hist[j-1];
            end
            if (!flow_in)                  ones_cnt <= '0;
            else if (ones_cnt != CW'(DEPTH)) ones_cnt <= ones_cnt + 1'b1;
            if (seen != CW'(DEPTH))          seen <= seen + 1'b1;
            if (!pack_vld)                 vld_run <= '0;
            else if (vld_run != CW'(DEPTH))  vld_run <= vld_run + 1'b1;
        end
    end

    // R1: reset clears the output and the valid flag.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pack_out == '0 && !pack_vld));

    // R2: an all-ones flow window gives a straight pipeline.
    p_straight_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flow_in && ones_cnt >= CW'(DEPTH-2) && seen >= CW'(DEPTH-1))
        |=> (pack_out == din_hist[DEPTH-1]));

    // R4: a burst starts only after a zero flow sample on an enabled clock.
    p_burst_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pack_vld) |-> $past(en && !flow_in));

    // R4: a burst never lasts more than DEPTH enabled clocks.
    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pack_vld) |-> (vld_run < CW'(DEPTH)));

    // R6: a disabled clock changes nothing at the outputs.
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pack_out) && $stable(pack_vld)));

endmodule

bind res_packer res_packer_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .flow_in  (flow_in),
    .res_in   (res_in),
    .pack_out (pack_out),
    .pack_vld (pack_vld)
);

// File: tb/res_packer_bench.sv
// Bench for the result byte packer: a logical schedule of straight-pipeline
// traffic and packed operations, with random stall bursts inserted between
// enabled clocks.
module res_packer_bench;

    localparam int L = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       flow_in = 1'b1;
    logic [7:0] res_in = 8'h00;
    logic [7:0] pack_out;
    logic       pack_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] s_din  [L];
    bit         s_flow [L];
    bit         e_chk  [L];
    logic [7:0] e_dout [L];
    bit         e_vld  [L];
    int         e_kind [L];

    always #10 clk = ~clk;

    res_packer u_res_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .flow_in  (flow_in),
        .res_in   (res_in),
        .pack_out (pack_out),
        .pack_vld (pack_vld)
    );

    function automatic string rq(input int kind);
        case (kind)
            1: return "R3";
            2: return "R5";
            3: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input bit e, input bit f, input logic [7:0] d);
        @(negedge clk);
        en = e; flow_in = f; res_in = d;
        @(posedge clk);
        #1;
    endtask

    // Place one packed operation in the schedule with its expected burst.
    task automatic place_op(input int st, input logic [7:0] b [4], input bit cmpl, input int kind);
        for (int i = 0; i < 4; i++) begin
            s_din[st + 2*i] = b[i];
            if (cmpl && i < 3) s_din[st + 2*i + 1] = ~b[i];
        end
        for (int i = 4; i < 7; i++) s_flow[st + i] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            e_chk[st + 6 + i]  = 1'b1;
            e_dout[st + 6 + i] = b[i];
            e_vld[st + 6 + i]  = 1'b1;
            e_kind[st + 6 + i] = kind;
        end
    endtask

    initial begin
        logic [7:0] b [4];
        int pos;
        void'($urandom(32'd20260117));
        for (int c = 0; c < L; c++) begin
            s_din[c] = 8'($urandom); s_flow[c] = 1'b1;
            e_chk[c] = 1'b0; e_dout[c] = 8'h00; e_vld[c] = 1'b0; e_kind[c] = 0;
        end
        // Directed: gap bytes are the complement of the real ones (R5).
        b = '{8'h00, 8'hFF, 8'h5A, 8'hA5};
        place_op(10, b, 1'b1, 2);
        // Directed: back-to-back operations (R7).
        b = '{8'h01, 8'h02, 8'h03, 8'h04};
        place_op(17, b, 1'b0, 3);
        b = '{8'h80, 8'h7F, 8'hC3, 8'h3C};
        place_op(24, b, 1'b0, 3);
        // Random placement of further packed operations (R3).
        pos = 40;
        while (pos < L - 20) begin
            if ($urandom % 2 == 0) begin
                for (int i = 0; i < 4; i++) b[i] = 8'($urandom);
                place_op(pos, b, 1'b0, 1);
                pos += 7 + int'($urandom % 6);
            end else begin
                pos += 1 + int'($urandom % 5);
            end
        end
        // Straight-pipeline expectations (R2) where no packed value applies.
        for (int c = 3; c < L; c++) begin
            if (!e_chk[c] && s_flow[c] && s_flow[c-1] && s_flow[c-2]) begin
                e_chk[c] = 1'b1; e_dout[c] = s_din[c-3]; e_kind[c] = 0;
            end
        end

        // R1: reset with random inputs.
        for (int i = 0; i < 3; i++) step(1'($urandom), 1'($urandom), 8'($urandom));
        check("R1", pack_out, 8'h00);
        check("R1", {7'd0, pack_vld}, 8'h00);
        rst_n = 1'b1;

        for (int c = 0; c < L; c++) begin
            if (c > 0 && $urandom % 6 == 0) begin
                logic [7:0] keep_d;
                logic       keep_v;
                int n;
                keep_d = pack_out; keep_v = pack_vld;
                n = 1 + int'($urandom % 3);
                for (int s = 0; s < n; s++) begin
                    step(1'b0, 1'($urandom), 8'($urandom));
                    check("R6", pack_out, keep_d);
                    check("R6", {7'd0, pack_vld}, {7'd0, keep_v});
                end
            end
            step(1'b1, s_flow[c], s_din[c]);
            check(e_vld[c] ? "R4" : "R4 (idle)", {7'd0, pack_vld}, {7'd0, e_vld[c]});
            if (e_chk[c]) check(rq(e_kind[c]), pack_out, e_dout[c]);
        end

        // R1: reset in mid-stream while data is non-zero.
        step(1'b1, 1'b1, 8'hEE);
        step(1'b1, 1'b1, 8'hEE);
        step(1'b1, 1'b1, 8'hEE);
        step(1'b1, 1'b1, 8'hEE);
        rst_n = 1'b0;
        step(1'b1, 1'b0, 8'h77);
        check("R1", pack_out, 8'h00);
        check("R1", {7'd0, pack_vld}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule